// File: doc/BRIEF.md
# Per-Half-Bridge PWM Low-Time and Bootstrap Recharge Guard

This block sits between a PWM modulator and the gate drivers of several half-bridges. The high-side driver of each half-bridge runs from a bootstrap capacitor, and that capacitor is only topped up while the output is low. The block splits time into PWM frames, which a one-cycle strobe marks, and counts the low cycles of each half-bridge's outgoing PWM in every frame. It also watches a per-half-bridge flag that reports whether the bootstrap supply is adequate.

A frame whose low time falls short of a parameterised minimum is flagged as a bootstrap fault on that half-bridge. That half-bridge then enters recharge, and so does one whose bootstrap flag dropped at any point in a frame. While in recharge, the first minimum-length stretch of every frame is forced low, so the capacitor gets a guaranteed charging window. Recharge ends after a frame in which the bootstrap flag stayed high throughout and the low time was adequate. All of this is per half-bridge. A problem on one never gates or flags another.

The minimum is given in system-clock cycles: 30 ns at 100 MHz gives 3 cycles. Frame length is set by the strobe alone, so any frame rate (for instance 384 kHz) works without a change to the design.

Top module: `bsm_bootstrap_monitor`

## Requirements
- R1: While reset is asserted, and until the first frame strobe after it, `recharge_active` and `boot_fault` are all zero and `pwm_out` equals `pwm_in`.
- R2: On a half-bridge that is not in recharge, `pwm_out` equals `pwm_in` in every cycle. The block can only force a bit low, never high.
- R3: The cycle carrying `frame_start` is the first cycle of a new frame. When a frame closes with fewer than MIN_LOW low cycles on a half-bridge's `pwm_out`, that bit of `boot_fault` is 1 from the strobe cycle to the cycle before the next strobe. Otherwise it is 0 for that span. Exactly MIN_LOW low cycles counts as adequate.
- R4: A short frame puts the half-bridge into recharge for the following frame. `recharge_active` is 1 from that frame's strobe cycle onward, and `pwm_out` is 0 in that frame's first MIN_LOW cycles, or in all of its cycles if the frame is shorter.
- R5: If `boot_ok` of a half-bridge is 0 in any cycle of a frame, including the strobe cycle, that half-bridge is in recharge for the next frame.
- R6: Recharge is released at the next strobe after a frame in which `boot_ok` stayed 1 in every cycle and the low time was at least MIN_LOW. Forced cycles count as low time.
- R7: Fault detection, recharge and forced pulses on one half-bridge never change the outputs of another.
- R8: The partial frame before the first strobe after reset is never judged, so the first strobe raises no fault and no recharge.
- R9: `recharge_active` and `boot_fault` change only in cycles that carry `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe marking the first cycle of a PWM frame |
| pwm_in | input | NUM_HB | PWM bit of each half-bridge from the modulator |
| boot_ok | input | NUM_HB | Bootstrap supply adequate, per half-bridge |
| pwm_out | output | NUM_HB | Gated PWM to the drivers |
| recharge_active | output | NUM_HB | Half-bridge is in recharge in the current frame |
| boot_fault | output | NUM_HB | Previous frame of this half-bridge was short of low time |

## Verification
The bench aims at the frame boundary. A design that counts the strobe cycle into the old frame, or compares with greater-than instead of greater-or-equal, misjudges a frame with exactly MIN_LOW low cycles or one with MIN_LOW-1. It also checks the first strobe after reset, where a design that judges the partial frame raises a spurious fault. Release is tested with the forced cycles as the only low time: a design that counts only the input PWM would never let go of recharge. Random frames, including frames shorter than MIN_LOW and bootstrap dropouts on single cycles, expose leakage between half-bridges and pulses that run past the strobe into the next frame.

// File: rtl/bsm_pkg.sv
// Shared definitions for the bootstrap low-time monitor.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package bsm_pkg;

    localparam int unsigned DEF_NUM_HB  = 4;
    localparam int unsigned DEF_MIN_LOW = 3;

    // Per-half-bridge frame verdict that is held for a whole frame
    typedef struct packed {
        logic recharge;
        logic fault;
    } hb_flags_t;

endpackage

// File: rtl/bsm_frame_timer.sv
// Frame timing shared by all half-bridges.
// Reports whether a strobe closes a judged frame, meaning a strobe has been
// seen since reset, and whether the current cycle lies inside the
// forced-low window at the start of a frame.
// Assumes: frame_start is a clean one-cycle strobe and MIN_LOW >= 1.
module bsm_frame_timer #(
    parameter int unsigned MIN_LOW = bsm_pkg::DEF_MIN_LOW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    output logic frame_close,
    output logic in_window
);
    localparam int unsigned CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] POS_MAX = CW'(MIN_LOW);

    logic [CW-1:0] pos_q;
    logic [CW-1:0] pos_cur;
    logic          seen_q;

    // Index of the current cycle within the frame, saturating at MIN_LOW
    always_comb begin
        pos_cur     = frame_start ? '0 : pos_q;
        in_window   = (pos_cur < POS_MAX);
        frame_close = frame_start & seen_q;
    end

    // Advance the position counter and remember the first strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= POS_MAX;
            seen_q <= 1'b0;
        end else begin
            pos_q <= (pos_cur == POS_MAX) ? POS_MAX : pos_cur + CW'(1);
            if (frame_start) begin
                seen_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bsm_hb_channel.sv
// One half-bridge: counts low cycles of the gated output per frame, tracks
// whether boot_ok stayed high for the whole frame, delivers the verdict at
// each judged strobe and forces the start of each recharge frame low.
// Assumes: frame_close and in_window come from bsm_frame_timer.
module bsm_hb_channel #(
    parameter int unsigned MIN_LOW = bsm_pkg::DEF_MIN_LOW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                frame_close,
    input  logic                in_window,
    input  logic                pwm_in,
    input  logic                boot_ok,
    output logic                pwm_out,
    output bsm_pkg::hb_flags_t  flags
);
    import bsm_pkg::*;

    localparam int unsigned CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LOW_MAX = CW'(MIN_LOW);

    logic [CW-1:0] low_q;
    logic          ok_q;
    hb_flags_t     flags_q;
    hb_flags_t     flags_cur;
    logic          short_frame;
    logic          out_low;

    // Verdict at a judged strobe, otherwise hold the verdict of this frame
    always_comb begin
        short_frame = (low_q < LOW_MAX);
        if (frame_close) begin
            flags_cur.fault    = short_frame;
            flags_cur.recharge = short_frame | ~ok_q;
        end else begin
            flags_cur = flags_q;
        end
        pwm_out = pwm_in & ~(flags_cur.recharge & in_window);
        out_low = ~pwm_out;
        flags   = flags_cur;
    end

    // Accumulate low time and bootstrap health, and register the verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q   <= '0;
            ok_q    <= 1'b1;
            flags_q <= '0;
        end else begin
            flags_q <= flags_cur;
            if (frame_start) begin
                low_q <= CW'(out_low);
                ok_q  <= boot_ok;
            end else begin
                low_q <= (low_q == LOW_MAX) ? LOW_MAX : low_q + CW'(out_low);
                ok_q  <= ok_q & boot_ok;
            end
        end
    end

endmodule

// File: rtl/bsm_bootstrap_monitor.sv
// Top level: one shared frame timer and NUM_HB independent half-bridge
// monitors.
// Assumes: all inputs are synchronous to clk. MIN_LOW is in clock cycles.
module bsm_bootstrap_monitor #(
    parameter int unsigned NUM_HB  = bsm_pkg::DEF_NUM_HB,
    parameter int unsigned MIN_LOW = bsm_pkg::DEF_MIN_LOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [NUM_HB-1:0] pwm_in,
    input  logic [NUM_HB-1:0] boot_ok,
    output logic [NUM_HB-1:0] pwm_out,
    output logic [NUM_HB-1:0] recharge_active,
    output logic [NUM_HB-1:0] boot_fault
);
    import bsm_pkg::*;

    logic frame_close;
    logic in_window;

    bsm_frame_timer #(
        .MIN_LOW (MIN_LOW)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_close (frame_close),
        .in_window   (in_window)
    );

    for (genvar g = 0; g < NUM_HB; g++) begin : g_hb
        hb_flags_t hb_flags;

        bsm_hb_channel #(
            .MIN_LOW (MIN_LOW)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .frame_close (frame_close),
            .in_window   (in_window),
            .pwm_in      (pwm_in[g]),
            .boot_ok     (boot_ok[g]),
            .pwm_out     (pwm_out[g]),
            .flags       (hb_flags)
        );

        // Unpack the per-channel verdict onto the output vectors
        always_comb begin
            recharge_active[g] = hb_flags.recharge;
            boot_fault[g]      = hb_flags.fault;
        end
    end

endmodule

// File: rtl/bsm_checker.sv
// Protocol assertions for bsm_bootstrap_monitor, attached by bind below.
// Assumes: rst_n is low from time zero until the first clock edges.
module bsm_checker #(
    parameter int unsigned NUM_HB = bsm_pkg::DEF_NUM_HB
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [NUM_HB-1:0] pwm_in,
    input logic [NUM_HB-1:0] pwm_out,
    input logic [NUM_HB-1:0] recharge_active,
    input logic [NUM_HB-1:0] boot_fault
);

    for (genvar g = 0; g < NUM_HB; g++) begin : g_chk
        // R2: a half-bridge outside recharge passes its PWM unchanged
        p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !recharge_active[g] |-> (pwm_out[g] == pwm_in[g]));

        // R2: gating can only pull low
        p_never_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_out[g] |-> pwm_in[g]);

        // R4: the strobe cycle of a recharge frame is always forced low
        p_force_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (recharge_active[g] && frame_start) |-> !pwm_out[g]);

        // R4: a faulted frame is always a recharge frame
        p_fault_recharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
            boot_fault[g] |-> recharge_active[g]);
    end

    // R9: verdicts hold between strobes
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> (recharge_active == $past(recharge_active)
                          && boot_fault == $past(boot_fault)));

endmodule

bind bsm_bootstrap_monitor bsm_checker #(
    .NUM_HB (NUM_HB)
) u_bsm_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_start     (frame_start),
    .pwm_in          (pwm_in),
    .pwm_out         (pwm_out),
    .recharge_active (recharge_active),
    .boot_fault      (boot_fault)
);

// File: tb/tb_bsm_bootstrap_monitor.sv
module tb_bsm_bootstrap_monitor;
    localparam int NHB = 4;
    localparam int MIN = 3;
    localparam int HALF = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_start = 1'b0;
    logic [NHB-1:0] pwm_in = '1;
    logic [NHB-1:0] boot_ok = '1;
    logic [NHB-1:0] pwm_out;
    logic [NHB-1:0] recharge_active;
    logic [NHB-1:0] boot_fault;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag = "R1";

    // Reference state, built from the requirements
    int m_low [NHB];
    bit m_ok  [NHB];
    bit m_rch [NHB];
    bit m_flt [NHB];
    int m_idx;
    bit m_seen;

    always #HALF clk = ~clk;

    bsm_bootstrap_monitor #(.NUM_HB(NHB), .MIN_LOW(MIN)) dut (
        .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
        .pwm_in (pwm_in), .boot_ok (boot_ok), .pwm_out (pwm_out),
        .recharge_active (recharge_active), .boot_fault (boot_fault)
    );

    task automatic model_reset();
        for (int i = 0; i < NHB; i++) begin
            m_low[i] = 0; m_ok[i] = 1; m_rch[i] = 0; m_flt[i] = 0;
        end
        m_idx = MIN;
        m_seen = 0;
    endtask

    task automatic check_vec(string what, logic [NHB-1:0] act, logic [NHB-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check, then advance the model
    task automatic step(bit fs, logic [NHB-1:0] pw, logic [NHB-1:0] bo);
        logic [NHB-1:0] e_out, e_rch, e_flt;
        int idx;
        frame_start = fs; pwm_in = pw; boot_ok = bo;
        #1;
        idx = fs ? 0 : m_idx;
        for (int i = 0; i < NHB; i++) begin
            bit shrt, cls;
            shrt = (m_low[i] < MIN);
            cls  = fs && m_seen && rst_n;
            e_rch[i] = !rst_n ? 1'b0 : (cls ? (shrt || !m_ok[i]) : m_rch[i]);
            e_flt[i] = !rst_n ? 1'b0 : (cls ? shrt : m_flt[i]);
            e_out[i] = pw[i] && !(e_rch[i] && idx < MIN);
        end
        check_vec("pwm_out", pwm_out, e_out);
        check_vec("recharge_active", recharge_active, e_rch);
        check_vec("boot_fault", boot_fault, e_flt);
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int i = 0; i < NHB; i++) begin
                if (fs) begin
                    m_rch[i] = e_rch[i]; m_flt[i] = e_flt[i];
                    m_low[i] = e_out[i] ? 0 : 1; m_ok[i] = bo[i];
                end else begin
                    m_low[i] += e_out[i] ? 0 : 1; m_ok[i] = m_ok[i] && bo[i];
                end
            end
            m_idx = fs ? 1 : m_idx + 1;
            if (fs) m_seen = 1;
        end
        @(negedge clk);
    endtask

    // Frame with given low counts at its end (ch0 / other channels)
    task automatic run_frame(int len, int lowa, int lowr, logic [NHB-1:0] bmask, string t);
        tag = t;
        for (int c = 0; c < len; c++) begin
            logic [NHB-1:0] pw;
            for (int i = 0; i < NHB; i++)
                pw[i] = (c >= len - ((i == 0) ? lowa : lowr)) ? 1'b0 : 1'b1;
            step(c == 0, pw, (c == len / 2) ? bmask : '1);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd24681);
        model_reset();
        @(negedge clk);
        // R1: reset state, strobes ignored while in reset
        tag = "R1";
        for (int k = 0; k < 4; k++) step(k == 1, NHB'($urandom), '0);
        rst_n = 1'b1;
        // R8: partial frame with no low time before the first strobe
        tag = "R8";
        for (int k = 0; k < 5; k++) step(1'b0, '1, '1);
        run_frame(8, MIN, MIN, '1, "R8");
        // R3: ch0 one cycle short, others exactly MIN (adequate)
        run_frame(8, MIN - 1, MIN, '1, "R3");
        // R4: ch0 recharging, forced window only low time
        run_frame(8, 0, MIN, '1, "R4");
        // R6: release of ch0 visible at this strobe
        run_frame(8, MIN, MIN, '1, "R6");
        // R5: ch1 loses bootstrap for one mid-frame cycle
        run_frame(8, MIN, MIN, 4'b1101, "R5");
        // R7: only ch1 recharges here
        run_frame(8, MIN, MIN, '1, "R7");
        // R5: dropout on the strobe cycle itself, ch2
        tag = "R5";
        step(1'b1, '0, 4'b1011);
        for (int k = 0; k < 6; k++) step(1'b0, '1, '1);
        run_frame(6, MIN, MIN, '1, "R5");
        // R4: frames shorter than the window
        run_frame(2, 0, 0, '1, "R4");
        run_frame(2, 0, 0, '1, "R4");
        // R2 R7 R9: random frames
        for (int f = 0; f < 2000; f++) begin
            int len;
            len = 2 + int'($urandom_range(12));
            tag = "R7";
            for (int c = 0; c < len; c++) begin
                logic [NHB-1:0] pw, bo;
                for (int i = 0; i < NHB; i++) begin
                    pw[i] = ($urandom_range(3) != 0);
                    bo[i] = ($urandom_range(29) != 0);
                end
                step(c == 0, pw, bo);
            end
        end
        finish_run();
    end

    initial begin
        #(2 * HALF * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired (%s) actual=running expected=done", tag);
        finish_run();
    end

endmodule